// File: doc/BRIEF.md
# Packed Time-of-Day Counter

This block keeps elapsed time as hours, minutes, seconds and 128ths of a second, all held in one 32-bit word rather than a plain binary count. The block takes a one-cycle tick from a 32,768 Hz source and divides it by 256. Each divided step adds one 1/128-second unit, and the fields carry into one another like a clock face.

Software or a neighbouring block can preset every field at once through a load port. The running value is presented in the same packed layout. A range select sets whether hours wrap after 23 or after 255. Two single-cycle event outputs mark each new second and each hours wrap.

The packed word places the 1/128-second count in bits 6:0, seconds in bits 13:8, minutes in bits 21:16 and hours in bits 31:24. Bits 7, 15:14 and 23:22 are spare and always read as zero.

Top module: `tod_counter`

## Requirements
- R1: Once reset is released, `time_o` reads 0x00000000 and both `sec_pulse_o` and `hr_wrap_o` are low.
- R2: The 1/128-second field (bits 6:0) advances by one on the 256th enabled tick counted from reset or from the last load. It stays unchanged on the 255 ticks before that.
- R3: When the 1/128-second field goes from 127 to 0, the seconds field (bits 13:8) advances. `sec_pulse_o` is high for exactly the one cycle in which the new seconds value first appears.
- R4: Seconds going from 59 to 0 advance the minutes field (bits 21:16). Minutes going from 59 to 0 advance the hours field (bits 31:24).
- R5: With `hr_ext_i` = 0, hours go from 23 to 0. `hr_wrap_o` pulses for one cycle together with that wrap.
- R6: With `hr_ext_i` = 1, hours count past 23 up to 255, then wrap to 0 with a `hr_wrap_o` pulse.
- R7: A cycle with `load_i` high copies the field bits of `load_val_i` into `time_o` on the next edge. The load clears the divide-by-256 phase and takes priority over a step in the same cycle.
- R8: Bits 7, 15:14 and 23:22 of `time_o` always read zero, whatever was loaded.
- R9: While `enable_i` is low, ticks neither change `time_o` nor advance the divider phase. The phase resumes where it stopped.
- R10: A loaded field value above its last legal value becomes 0 on the next step of that field and carries into the next field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per 32,768 Hz source period |
| enable_i | input | 1 | Count enable |
| hr_ext_i | input | 1 | Hours range: 0 wraps after 23, 1 wraps after 255 |
| load_i | input | 1 | Preset strobe |
| load_val_i | input | 32 | Preset value in the packed layout |
| time_o | output | 32 | Current time in the packed layout |
| sec_pulse_o | output | 1 | One-cycle pulse on every seconds increment |
| hr_wrap_o | output | 1 | One-cycle pulse when hours wrap to 0 |

## Verification
The bench aims at the points where the cascade is easy to get wrong:
- Full-carry values such as 23:59:59:127 in both hour ranges. A counter that wraps hours at the wrong limit would show 24 where 0 belongs, or 0 where 24 belongs.
- A preset of all ones. This catches spare bits that leak into `time_o` and out-of-range fields that never clamp to zero.
- A divider that keeps counting while disabled, or that keeps its phase across a load. Either fault shifts the increment away from the exact 256th tick, and the bench checks one tick before that point as well as at it.
- A load colliding with a step. A step that beats the load would leave the preset value plus one in `time_o`.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SUB_LSB = 0;
  localparam int SUB_W   = 7;
  localparam int SEC_LSB = 8;
  localparam int SEC_W   = 6;
  localparam int MIN_LSB = 16;
  localparam int MIN_W   = 6;
  localparam int HR_LSB  = 24;
  localparam int HR_W    = 8;
  localparam int WORD_W  = 32;

  localparam logic [SUB_W-1:0] SUB_LAST   = 7'd127;
  localparam logic [SEC_W-1:0] SEC_LAST   = 6'd59;
  localparam logic [MIN_W-1:0] MIN_LAST   = 6'd59;
  localparam logic [HR_W-1:0]  HR_LAST24  = 8'd23;
  localparam logic [HR_W-1:0]  HR_LASTEXT = 8'd255;

  function automatic logic [WORD_W-1:0] field_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[SUB_LSB +: SUB_W] = '1;
    m[SEC_LSB +: SEC_W] = '1;
    m[MIN_LSB +: MIN_W] = '1;
    m[HR_LSB  +: HR_W]  = '1;
    return m;
  endfunction
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic enable_i,
  input  logic clr_i,
  output logic step_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             adv;

  assign adv    = tick_i & enable_i;
  assign step_o = adv & (cnt_q == {DIV_W{1'b1}}) & ~clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  // R9: phase frozen while disabled
  p_phase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!enable_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  logic [W-1:0] q_q, q_d;
  logic         at_end;

  assign at_end  = (q_q >= last_i);
  assign carry_o = inc_i & ~ld_i & at_end;

  always_comb begin
    q_d = q_q;
    if (ld_i)        q_d = ld_val_i;
    else if (inc_i)  q_d = at_end ? '0 : q_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= '0;
    else          q_q <= q_d;
  end

  assign q_o = q_q;

  // R4: in-range field steps by one
  p_field_step_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (inc_i && !ld_i && (q_q < last_i)) |=> (q_q == $past(q_q) + 1'b1));
  // R10: at or beyond the last legal value the field returns to zero
  p_field_clamp_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (inc_i && !ld_i && (q_q >= last_i)) |=> (q_q == '0));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tick_i,
  input  logic              enable_i,
  input  logic              hr_ext_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] time_o,
  output logic              sec_pulse_o,
  output logic              hr_wrap_o
);
  localparam logic [WORD_W-1:0] KEEP = field_mask();

  logic             rst_n;
  logic             step;
  logic [SUB_W-1:0] sub_q;
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hr_q;
  logic             sub_cy, sec_cy, min_cy, hr_cy;
  logic [HR_W-1:0]  hr_last;
  logic             sec_pulse_q, sec_pulse_d;
  logic             hr_wrap_q, hr_wrap_d;

  tod_rst_sync u_rst (.clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n));

  tod_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i(clk_i), .rst_n_i(rst_n), .tick_i(tick_i), .enable_i(enable_i),
    .clr_i(load_i), .step_o(step)
  );

  assign hr_last = hr_ext_i ? HR_LASTEXT : HR_LAST24;

  tod_field #(.W(SUB_W)) u_sub (
    .clk_i(clk_i), .rst_n_i(rst_n), .inc_i(step), .ld_i(load_i),
    .ld_val_i(load_val_i[SUB_LSB +: SUB_W]), .last_i(SUB_LAST),
    .q_o(sub_q), .carry_o(sub_cy)
  );
  tod_field #(.W(SEC_W)) u_sec (
    .clk_i(clk_i), .rst_n_i(rst_n), .inc_i(sub_cy), .ld_i(load_i),
    .ld_val_i(load_val_i[SEC_LSB +: SEC_W]), .last_i(SEC_LAST),
    .q_o(sec_q), .carry_o(sec_cy)
  );
  tod_field #(.W(MIN_W)) u_min (
    .clk_i(clk_i), .rst_n_i(rst_n), .inc_i(sec_cy), .ld_i(load_i),
    .ld_val_i(load_val_i[MIN_LSB +: MIN_W]), .last_i(MIN_LAST),
    .q_o(min_q), .carry_o(min_cy)
  );
  tod_field #(.W(HR_W)) u_hr (
    .clk_i(clk_i), .rst_n_i(rst_n), .inc_i(min_cy), .ld_i(load_i),
    .ld_val_i(load_val_i[HR_LSB +: HR_W]), .last_i(hr_last),
    .q_o(hr_q), .carry_o(hr_cy)
  );

  always_comb begin
    sec_pulse_d = sub_cy;
    hr_wrap_d   = hr_cy;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sec_pulse_q <= 1'b0;
      hr_wrap_q   <= 1'b0;
    end else begin
      sec_pulse_q <= sec_pulse_d;
      hr_wrap_q   <= hr_wrap_d;
    end
  end

  always_comb begin
    time_o = '0;
    time_o[SUB_LSB +: SUB_W] = sub_q;
    time_o[SEC_LSB +: SEC_W] = sec_q;
    time_o[MIN_LSB +: MIN_W] = min_q;
    time_o[HR_LSB  +: HR_W]  = hr_q;
  end

  assign sec_pulse_o = sec_pulse_q;
  assign hr_wrap_o   = hr_wrap_q;

  // R8: spare bits never set
  p_rsv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (time_o & ~KEEP) == '0);
  // R7: load lands on the next edge
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> (time_o == ($past(load_val_i) & KEEP)));
  // R3: a seconds pulse coincides with a fresh sub-second zero and is one cycle long
  p_sec_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    sec_pulse_o |-> (time_o[SUB_LSB +: SUB_W] == '0));
  // R5: a wrap pulse comes with all upper fields at zero
  p_hr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    hr_wrap_o |-> (sec_pulse_o && time_o == '0));
  // R9: disabled and not loading means frozen
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!enable_i && !load_i) |=> $stable(time_o));
endmodule

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, en, ext, ld;
  logic [31:0] ld_val;
  logic [31:0] time_o;
  logic        sec_p, hr_w;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  tod_counter u_tod_counter (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .enable_i(en),
    .hr_ext_i(ext), .load_i(ld), .load_val_i(ld_val),
    .time_o(time_o), .sec_pulse_o(sec_p), .hr_wrap_o(hr_w)
  );

  function automatic logic [31:0] pk(int h, int m, int s, int f);
    return {h[7:0], 2'b00, m[5:0], 2'b00, s[5:0], 1'b0, f[6:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] v);
    ld = 1'b1; ld_val = v;
    @(negedge clk);
    ld = 1'b0; ld_val = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 time", time_o, 32'h0);
    chk("R1 pulses", {30'd0, sec_p, hr_w}, 32'h0);
  endtask

  task automatic t_prescale;
    do_load(pk(0, 0, 0, 5));
    ticks(255);
    chk("R2 before 256th", time_o, pk(0, 0, 0, 5));
    ticks(1);
    chk("R2 at 256th", time_o, pk(0, 0, 0, 6));
  endtask

  task automatic t_sec_carry;
    do_load(pk(0, 0, 5, 127));
    ticks(256);
    chk("R3 sec carry", time_o, pk(0, 0, 6, 0));
    chk("R3 pulse high", {31'd0, sec_p}, 32'd1);
    @(negedge clk);
    chk("R3 pulse one cycle", {31'd0, sec_p}, 32'd0);
  endtask

  task automatic t_min_hr_carry;
    do_load(pk(3, 59, 59, 127));
    ticks(256);
    chk("R4 cascade", time_o, pk(4, 0, 0, 0));
    chk("R4 no wrap", {31'd0, hr_w}, 32'd0);
  endtask

  task automatic t_wrap24;
    ext = 1'b0;
    do_load(pk(23, 59, 59, 127));
    ticks(256);
    chk("R5 wrap 24", time_o, 32'h0);
    chk("R5 wrap pulse", {31'd0, hr_w}, 32'd1);
    @(negedge clk);
    chk("R5 wrap pulse one cycle", {31'd0, hr_w}, 32'd0);
  endtask

  task automatic t_ext;
    ext = 1'b1;
    do_load(pk(23, 59, 59, 127));
    ticks(256);
    chk("R6 past 23", time_o, pk(24, 0, 0, 0));
    chk("R6 no pulse", {31'd0, hr_w}, 32'd0);
    do_load(pk(255, 59, 59, 127));
    ticks(256);
    chk("R6 wrap 256", time_o, 32'h0);
    chk("R6 wrap pulse", {31'd0, hr_w}, 32'd1);
    ext = 1'b0;
  endtask

  task automatic t_load_rsv_clamp;
    ext = 1'b1;
    do_load(32'hFFFF_FFFF);
    chk("R8 spare bits dropped", time_o, 32'hFF3F_3F7F);
    ticks(256);
    chk("R10 clamp all fields", time_o, 32'h0);
    do_load(pk(1, 2, 62, 127));
    ticks(256);
    chk("R10 seconds clamp carries", time_o, pk(1, 3, 0, 0));
    ext = 1'b0;
  endtask

  task automatic t_load_priority;
    do_load(pk(0, 0, 0, 10));
    ticks(255);
    tick = 1'b1; ld = 1'b1; ld_val = pk(7, 7, 7, 7);
    @(negedge clk);
    tick = 1'b0; ld = 1'b0; ld_val = '0;
    chk("R7 load beats step", time_o, pk(7, 7, 7, 7));
    ticks(255);
    chk("R7 phase cleared", time_o, pk(7, 7, 7, 7));
    ticks(1);
    chk("R7 step after full period", time_o, pk(7, 7, 7, 8));
  endtask

  task automatic t_enable;
    do_load(pk(2, 0, 0, 0));
    ticks(100);
    en = 1'b0;
    ticks(700);
    chk("R9 frozen while disabled", time_o, pk(2, 0, 0, 0));
    en = 1'b1;
    ticks(155);
    chk("R9 phase kept, one short", time_o, pk(2, 0, 0, 0));
    ticks(1);
    chk("R9 phase resumed", time_o, pk(2, 0, 0, 1));
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; en = 1'b1; ext = 1'b0; ld = 1'b0; ld_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_prescale;
    t_sec_carry;
    t_min_hr_carry;
    t_wrap24;
    t_ext;
    t_load_rsv_clamp;
    t_load_priority;
    t_enable;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule